// File: doc/BRIEF.md
# ADC Result Overwrite Protection Controller

This block is the digital sequencer that sits beside a converter core holding only one result register. It starts conversions, loads each finished sample into the result register and raises an interrupt flag. It also stops a later sample from replacing one that has not been consumed yet. The analog front end, the conversion datapath, the memory mover and the register decode are outside it.

When interrupts are enabled, each stored result freezes further conversion. The freeze is released in one of two ways, chosen at the moment the sample is captured. In software service, the freeze ends when software clears the interrupt flag. In transfer service, a visible pause flag and a transfer request stay high until the mover reports completion. After release, continuous mode starts the next conversion at once, and single mode goes back to idle to wait for a new start. With interrupts disabled, results overwrite freely and nothing pauses.

Top module: `adc_guard_ctrl`

## Requirements
- R1: After reset the result register is all zero, the interrupt flag, interrupt request, pause flag, transfer request and convert-go are all 0, and the controller is idle.
- R2: A start pulse while idle asserts convert-go from the next clock edge. Convert-go is 1 exactly while the controller is converting.
- R3: A done strobe while converting loads the sample into the result register and sets the interrupt flag at that edge.
- R4: The interrupt request equals the interrupt flag ANDed with interrupt enable.
- R5: With interrupt enable at 1 on a capture, the controller pauses and convert-go drops from the next edge until the pause is released.
- R6: In software service (transfer enable 0 at capture), a flag clear releases the pause.
- R7: With continuous mode at 1 on release, or on a non-pausing capture, convert-go stays or returns high on the next edge.
- R8: With continuous mode at 0, release or a non-pausing capture returns the controller to idle (convert-go 0) until a new start.
- R9: A done strobe that arrives while idle or paused leaves the result register and the flag unchanged.
- R10: A flag clear in the same cycle as a capture leaves the flag set.
- R11: In transfer service (transfer enable 1 at capture, with interrupt enable 1), the pause flag and the transfer request are 1 during the pause, and a flag clear does not release it.
- R12: A transfer-complete strobe during a transfer-service pause clears the pause flag, the transfer request and the interrupt flag on the next edge, and releases the pause.
- R13: With interrupt enable at 0 on a capture, the interrupt flag sets, no pause occurs, and a later done strobe overwrites the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, acted on while idle |
| cont_i | input | 1 | 1 selects continuous conversion |
| irq_en_i | input | 1 | Interrupt enable; also enables protection |
| xfer_en_i | input | 1 | 1 selects transfer service for the pause |
| conv_done_i | input | 1 | Conversion-finished strobe from the core |
| conv_data_i | input | RES_W | Sample that comes with the done strobe |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| xfer_done_i | input | 1 | Transfer-complete strobe from the mover |
| result_o | output | RES_W | Result register |
| int_flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request |
| pause_o | output | 1 | Pause flag for transfer service |
| xfer_req_o | output | 1 | Request to move the result to memory |
| conv_go_o | output | 1 | Convert command to the core |

## Verification
Every registered result is due on the first clock edge after the cycle that holds its stimulus. This covers the result register, the flag, the pause flag, the transfer request and convert-go. The interrupt request follows the flag and the enable without delay. The driver applies one cycle of inputs at a falling edge and queues the values due after the next rising edge. The monitor pops each item one nanosecond after that rising edge, while the inputs are still held, so the comparison always falls in the cycle the requirement names.

// File: rtl/adc_guard_ctrl.sv
module adc_guard_ctrl #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             irq_en_i,
  input  logic             xfer_en_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic             flag_clr_i,
  input  logic             xfer_done_i,
  output logic [RES_W-1:0] result_o,
  output logic             int_flag_o,
  output logic             irq_o,
  output logic             pause_o,
  output logic             xfer_req_o,
  output logic             conv_go_o
);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_HOLD} st_t;

  st_t              st_q, st_d;
  logic [RES_W-1:0] res_q;
  logic             flag_q, pause_q, xmode_q;

  wire capture = (st_q == S_CONV) && conv_done_i;
  wire release_hold = (st_q == S_HOLD) && (xmode_q ? xfer_done_i : flag_clr_i);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start_i) st_d = S_CONV;
      S_CONV: if (conv_done_i) begin
        if (irq_en_i)    st_d = S_HOLD;
        else if (!cont_i) st_d = S_IDLE;
      end
      S_HOLD: if (release_hold) st_d = cont_i ? S_CONV : S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      res_q   <= '0;
      flag_q  <= 1'b0;
      pause_q <= 1'b0;
      xmode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (capture) begin
        res_q   <= conv_data_i;
        xmode_q <= xfer_en_i;
      end
      if (capture)
        flag_q <= 1'b1;
      else if (flag_clr_i || (release_hold && xmode_q))
        flag_q <= 1'b0;
      if (capture && irq_en_i && xfer_en_i)
        pause_q <= 1'b1;
      else if (release_hold)
        pause_q <= 1'b0;
    end
  end

  assign result_o   = res_q;
  assign int_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i;
  assign pause_o    = pause_q;
  assign xfer_req_o = pause_q;
  assign conv_go_o  = (st_q == S_CONV);

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go_o && conv_done_i) |=> int_flag_o); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_go_o && conv_done_i) |=> $stable(result_o)); // R9
  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go_o && conv_done_i && irq_en_i) |=> !conv_go_o); // R5
  AST_NO_PAUSE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go_o && conv_done_i && !irq_en_i && cont_i) |=> (conv_go_o && !pause_o)); // R13
  AST_GO_OFF_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_o |-> !conv_go_o); // R11
  AST_XFER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_o && xfer_done_i) |=> (!pause_o && !xfer_req_o && !int_flag_o)); // R12
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go_o && conv_done_i && flag_clr_i) |=> int_flag_o); // R10

endmodule

// File: tb/tb_adc_guard_ctrl.sv
`timescale 1ns/1ps
module tb_adc_guard_ctrl;
  localparam int RES_W = 10;

  typedef struct {
    logic [RES_W-1:0] res;
    logic flag, irq, pause, xreq, go;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, cont_i = 0, irq_en_i = 0, xfer_en_i = 0;
  logic conv_done_i = 0, flag_clr_i = 0, xfer_done_i = 0;
  logic [RES_W-1:0] conv_data_i = '0;
  logic [RES_W-1:0] result_o;
  logic int_flag_o, irq_o, pause_o, xfer_req_o, conv_go_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  adc_guard_ctrl #(.RES_W(RES_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
    .irq_en_i(irq_en_i), .xfer_en_i(xfer_en_i), .conv_done_i(conv_done_i),
    .conv_data_i(conv_data_i), .flag_clr_i(flag_clr_i), .xfer_done_i(xfer_done_i),
    .result_o(result_o), .int_flag_o(int_flag_o), .irq_o(irq_o),
    .pause_o(pause_o), .xfer_req_o(xfer_req_o), .conv_go_o(conv_go_o)
  );

  task automatic compare(input exp_t e);
    logic [RES_W+4:0] act, want;
    act  = {result_o, int_flag_o, irq_o, pause_o, xfer_req_o, conv_go_o};
    want = {e.res, e.flag, e.irq, e.pause, e.xreq, e.go};
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s: actual res=%h flag=%b irq=%b pause=%b xreq=%b go=%b expected res=%h flag=%b irq=%b pause=%b xreq=%b go=%b",
        e.tag, result_o, int_flag_o, irq_o, pause_o, xfer_req_o, conv_go_o,
        e.res, e.flag, e.irq, e.pause, e.xreq, e.go);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(input logic st, co, ie, xe, dn, input logic [RES_W-1:0] d,
                      input logic clr, xd,
                      input logic [RES_W-1:0] eres, input logic ef, ei, ep, ex, eg,
                      input string tag);
    exp_t e;
    @(negedge clk);
    start_i = st; cont_i = co; irq_en_i = ie; xfer_en_i = xe;
    conv_done_i = dn; conv_data_i = d; flag_clr_i = clr; xfer_done_i = xd;
    e.res = eres; e.flag = ef; e.irq = ei; e.pause = ep; e.xreq = ex; e.go = eg;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    begin
      exp_t r;
      r.res = '0; r.flag = 0; r.irq = 0; r.pause = 0; r.xreq = 0; r.go = 0;
      r.tag = "R1 reset state";
      compare(r);
    end
    @(negedge clk); rst_n = 1'b1;
    //   st co ie xe dn data    clr xd   res     f i p x g
    step(0, 0, 0, 0, 0, 10'h000, 0, 0, 10'h000, 0,0,0,0,0, "R1 idle after reset");
    // software service, single
    step(1, 0, 1, 0, 0, 10'h000, 0, 0, 10'h000, 0,0,0,0,1, "R2 start asserts go");
    step(0, 0, 1, 0, 1, 10'h155, 0, 0, 10'h155, 1,1,0,0,0, "R3 R4 R5 capture pauses");
    step(0, 0, 1, 0, 1, 10'h2AA, 0, 0, 10'h155, 1,1,0,0,0, "R9 done while paused ignored");
    step(0, 0, 0, 0, 0, 10'h000, 0, 0, 10'h155, 1,0,0,0,0, "R4 irq masked by enable");
    step(0, 0, 1, 0, 0, 10'h000, 1, 0, 10'h155, 0,0,0,0,0, "R6 R8 clear releases to idle");
    step(0, 0, 1, 0, 0, 10'h000, 0, 0, 10'h155, 0,0,0,0,0, "R8 stays idle");
    // software service, continuous
    step(1, 1, 1, 0, 0, 10'h000, 0, 0, 10'h155, 0,0,0,0,1, "R2 start continuous");
    step(0, 1, 1, 0, 1, 10'h0F0, 0, 0, 10'h0F0, 1,1,0,0,0, "R5 continuous capture pauses");
    step(0, 1, 1, 0, 0, 10'h000, 1, 0, 10'h0F0, 0,0,0,0,1, "R7 clear restarts");
    step(0, 1, 1, 0, 1, 10'h3FF, 1, 0, 10'h3FF, 1,1,0,0,0, "R10 set beats clear");
    step(0, 0, 1, 0, 0, 10'h000, 1, 0, 10'h3FF, 0,0,0,0,0, "R8 release to idle");
    // transfer service
    step(1, 0, 1, 1, 0, 10'h000, 0, 0, 10'h3FF, 0,0,0,0,1, "R2 start transfer mode");
    step(0, 0, 1, 1, 1, 10'h123, 0, 0, 10'h123, 1,1,1,1,0, "R11 pause and request set");
    step(0, 0, 1, 1, 0, 10'h000, 1, 0, 10'h123, 0,0,1,1,0, "R11 clear does not release");
    step(0, 1, 1, 1, 0, 10'h000, 0, 1, 10'h123, 0,0,0,0,1, "R12 R7 transfer done restarts");
    step(0, 1, 1, 1, 1, 10'h001, 0, 0, 10'h001, 1,1,1,1,0, "R11 second transfer pause");
    step(0, 0, 1, 1, 0, 10'h000, 0, 1, 10'h001, 0,0,0,0,0, "R12 R8 transfer done to idle");
    // protection off
    step(1, 1, 0, 0, 0, 10'h000, 0, 0, 10'h001, 0,0,0,0,1, "R2 start no protection");
    step(0, 1, 0, 0, 1, 10'h0AB, 0, 0, 10'h0AB, 1,0,0,0,1, "R13 capture without pause");
    step(0, 1, 0, 0, 1, 10'h0CD, 0, 0, 10'h0CD, 1,0,0,0,1, "R13 overwrite");
    step(0, 0, 0, 0, 0, 10'h000, 1, 0, 10'h0CD, 0,0,0,0,1, "R13 clear while converting");
    step(0, 0, 0, 0, 1, 10'h0EE, 0, 0, 10'h0EE, 1,0,0,0,0, "R8 single capture to idle");
    step(0, 0, 0, 0, 1, 10'h111, 1, 0, 10'h0EE, 0,0,0,0,0, "R9 done while idle ignored");
    step(0, 0, 0, 0, 0, 10'h000, 0, 0, 10'h0EE, 0,0,0,0,0, "R9 result unchanged");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule